// File: doc/BRIEF.md
# Gray-Level Byte Loader with Chip-Select Cascade

This block fills a bank of per-channel 8-bit gray levels from a byte-wide parallel bus. It does not use a valid/ready handshake. A byte is captured each time an external shift clock changes level, so a rising transition and a falling transition each capture one byte. The shift clock, the select input and the bus are all sampled by the faster system clock through the same two-stage alignment chain. A change in the sampled shift-clock level counts as one capture event, and the aligned bus value is stored in that same system-clock cycle.

The first byte after selection goes to channel 1, the next to channel 2, and so on up to the last channel. When the last channel slot is written, the cascade output goes high so that a following device takes the next bytes. Further transitions then have no effect until the select input drops and rises again. Dropping select returns the write position to channel 1 and clears the cascade output, but the stored levels stay as they are. The stored levels feed a pulse-width stage outside this block.

The loader cannot stall the sender, so there is no back-pressure. The sender must hold each shift-clock level, and the bus and select values that go with it, for at least three system-clock cycles.

Top module: `gray_latch_loader`

## Requirements
- R1: A synchronous active-high reset clears every channel level to 0 and drives `sel_next_o` low. A reset in mid-load also returns the write position to channel 1.
- R2: Both a low-to-high and a high-to-low change of `shclk_i` capture one byte each, so 32 channels fill in 16 full shift-clock periods.
- R3: The k-th byte captured since selection is stored in channel k. Channel k occupies `level_o[8*(k-1) +: 8]`.
- R4: A bus byte is stored unchanged, with `din_i[7]` as the most significant bit of the channel level, at bit `8*(k-1)+7` of `level_o`.
- R5: While `sel_i` is low, or in the cycle where it falls together with a shift-clock change, no channel level changes.
- R6: `sel_next_o` goes high in the cycle in which the last channel is written, and not before. After 31 captures it is still low.
- R7: Shift-clock changes after the last channel is written leave every level unchanged, and `sel_next_o` stays high while `sel_i` stays high.
- R8: When `sel_i` goes low, `sel_next_o` clears and the stored levels are kept. The next capture after re-selection writes channel 1.
- R9: A byte driven together with a shift-clock change appears on `level_o` after the third rising system-clock edge. It does not appear after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| shclk_i | input | 1 | Shift clock; each level change captures one byte |
| sel_i | input | 1 | Chip-select input; loading is enabled while high |
| din_i | input | 8 | Gray-level byte, bit 7 most significant |
| sel_next_o | output | 1 | Chip-select cascade output to the next device |
| level_o | output | 256 | Stored channel levels, channel k at bits 8*(k-1)+7 down to 8*(k-1) |

## Verification
Two things can land in the same system-clock cycle: a capture event, and the select input falling or the bank having just filled. The bench forces this by flipping the shift clock and dropping select on the same clock edge, at the point where the final channel is due. It then expects neither the last slot to be written nor the cascade output to rise. A reset arriving in the middle of a load is also provoked, and is judged against a behavioural model that sees the same sampled inputs every clock.

// File: rtl/gray_latch_pkg.sv
package gray_latch_pkg;
  parameter int unsigned DEF_CHANNELS = 32;
  parameter int unsigned DEF_BYTE_W   = 8;
  parameter int unsigned DEF_SYNC     = 2;

  function automatic int unsigned ptr_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sig_align.sv
module sig_align #(
  parameter int unsigned WIDTH  = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[s] <= '0;
        else       stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[s] <= '0;
        else       stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/load_ctrl.sv
module load_ctrl #(
  parameter int unsigned CHANNELS = 32,
  localparam int unsigned PW = gray_latch_pkg::ptr_width(CHANNELS)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          shclk_s_i,
  input  logic          sel_s_i,
  output logic          evt_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_idx_o,
  output logic          full_o
);
  localparam logic [PW-1:0] LAST_IDX = PW'(CHANNELS - 1);

  logic          shclk_prev;
  logic [PW-1:0] ptr_q;
  logic          full_q;

  assign evt_o    = shclk_s_i ^ shclk_prev;
  assign wr_en_o  = sel_s_i && evt_o && !full_q;
  assign wr_idx_o = ptr_q;
  assign full_o   = full_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      shclk_prev <= 1'b0;
      ptr_q      <= '0;
      full_q     <= 1'b0;
    end else begin
      shclk_prev <= shclk_s_i;
      if (!sel_s_i) begin
        ptr_q  <= '0;
        full_q <= 1'b0;
      end else if (evt_o && !full_q) begin
        if (ptr_q == LAST_IDX) full_q <= 1'b1;
        else                   ptr_q  <= ptr_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/level_bank.sv
module level_bank #(
  parameter int unsigned CHANNELS = 32,
  parameter int unsigned BYTE_W   = 8,
  localparam int unsigned PW = gray_latch_pkg::ptr_width(CHANNELS)
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic                         wr_en_i,
  input  logic [PW-1:0]                wr_idx_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  output logic [CHANNELS*BYTE_W-1:0]   level_o
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [BYTE_W-1:0] lvl_q;
    always_ff @(posedge clk_i) begin
      if (rst_i)                                   lvl_q <= '0;
      else if (wr_en_i && (wr_idx_i == PW'(c)))   lvl_q <= wr_data_i;
    end
    assign level_o[c*BYTE_W +: BYTE_W] = lvl_q;
  end
endmodule

// File: rtl/gray_latch_loader.sv
module gray_latch_loader #(
  parameter int unsigned CHANNELS    = gray_latch_pkg::DEF_CHANNELS,
  parameter int unsigned BYTE_W      = gray_latch_pkg::DEF_BYTE_W,
  parameter int unsigned SYNC_STAGES = gray_latch_pkg::DEF_SYNC,
  localparam int unsigned PW = gray_latch_pkg::ptr_width(CHANNELS),
  localparam int unsigned AW = BYTE_W + 2
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       shclk_i,
  input  logic                       sel_i,
  input  logic [BYTE_W-1:0]          din_i,
  output logic                       sel_next_o,
  output logic [CHANNELS*BYTE_W-1:0] level_o
);
  logic [AW-1:0]     aligned;
  logic              shclk_s;
  logic              sel_s;
  logic [BYTE_W-1:0] data_s;
  logic              shift_evt;
  logic              wr_en;
  logic [PW-1:0]     wr_idx;
  logic              load_full;

  sig_align #(.WIDTH(AW), .STAGES(SYNC_STAGES)) u_align (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   ({shclk_i, sel_i, din_i}),
    .q_o   (aligned)
  );

  assign shclk_s = aligned[AW-1];
  assign sel_s   = aligned[AW-2];
  assign data_s  = aligned[BYTE_W-1:0];

  load_ctrl #(.CHANNELS(CHANNELS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .shclk_s_i (shclk_s),
    .sel_s_i   (sel_s),
    .evt_o     (shift_evt),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .full_o    (load_full)
  );

  level_bank #(.CHANNELS(CHANNELS), .BYTE_W(BYTE_W)) u_bank (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (data_s),
    .level_o   (level_o)
  );

  assign sel_next_o = load_full;
endmodule

// File: rtl/gray_latch_loader_chk.sv
module gray_latch_loader_chk #(
  parameter int unsigned CHANNELS = 32,
  parameter int unsigned BYTE_W   = 8,
  localparam int unsigned PW = gray_latch_pkg::ptr_width(CHANNELS)
) (
  input logic                       clk_i,
  input logic                       rst_i,
  input logic                       sel_s,
  input logic                       evt,
  input logic [PW-1:0]              ptr,
  input logic                       full,
  input logic                       cso,
  input logic [CHANNELS*BYTE_W-1:0] level
);
  localparam logic [PW-1:0] LAST_IDX = PW'(CHANNELS - 1);

  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (!cso && level == '0));

  p_ptr_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_s && evt && !full && ptr != LAST_IDX) |=> (ptr == $past(ptr) + PW'(1)));

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !sel_s |=> $stable(level));

  p_cso_only_at_last_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(cso) |-> ($past(ptr) == LAST_IDX && $past(evt)));

  p_full_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (full && sel_s) |=> ($stable(level) && cso));

  p_deselect_home_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !sel_s |=> (!cso && ptr == '0));
endmodule

bind gray_latch_loader gray_latch_loader_chk #(.CHANNELS(CHANNELS), .BYTE_W(BYTE_W)) u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .sel_s (sel_s),
  .evt   (shift_evt),
  .ptr   (wr_idx),
  .full  (load_full),
  .cso   (sel_next_o),
  .level (level_o)
);

// File: tb/gray_latch_loader_bench.sv
module gray_latch_loader_bench;
  localparam int NCH = 32;
  localparam int LW  = NCH * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          shclk = 1'b0;
  logic          sel = 1'b0;
  logic [7:0]    din = 8'h00;
  logic          sel_next;
  logic [LW-1:0] level;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gray_latch_loader u_gray_latch_loader (
    .clk_i      (clk),
    .rst_i      (rst),
    .shclk_i    (shclk),
    .sel_i      (sel),
    .din_i      (din),
    .sel_next_o (sel_next),
    .level_o    (level)
  );

  // behavioural reference: queue of input samples, one per clock
  typedef struct { bit s; bit c; logic [7:0] d; } smp_t;
  smp_t        hist[$];
  logic [7:0]  m_lvl [NCH];
  int          m_pos;
  bit          m_full;
  bit          m_live = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      for (int i = 0; i < 3; i++) hist.push_back('{s:1'b0, c:1'b0, d:8'h00});
      for (int i = 0; i < NCH; i++) m_lvl[i] = 8'h00;
      m_pos  = 0;
      m_full = 1'b0;
      m_live = 1'b1;
    end else if (m_live) begin
      if (!hist[1].c) begin
        m_pos  = 0;
        m_full = 1'b0;
      end else if ((hist[1].s != hist[0].s) && !m_full) begin
        m_lvl[m_pos] = hist[1].d;
        if (m_pos == NCH - 1) m_full = 1'b1;
        else                  m_pos  = m_pos + 1;
      end
      hist.push_back('{s:shclk, c:sel, d:din});
      void'(hist.pop_front());
    end
  end

  function automatic logic [LW-1:0] model_flat();
    logic [LW-1:0] f;
    for (int i = 0; i < NCH; i++) f[i*8 +: 8] = m_lvl[i];
    return f;
  endfunction

  always @(negedge clk) begin
    if (m_live && !finished) begin
      total++;
      if (level !== model_flat() || sel_next !== m_full) begin
        bad++;
        $display("FAIL R9 model mismatch: level=%h cso=%b expected level=%h cso=%b",
                 level, sel_next, model_flat(), m_full);
      end
    end
  end

  task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edge_byte(input logic [7:0] v);
    @(negedge clk);
    din   = v;
    shclk = ~shclk;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk);
    sel = v;
    repeat (4) @(negedge clk);
  endtask

  logic [7:0]    exp_lvl [NCH];
  logic [LW-1:0] snap;

  function automatic logic [LW-1:0] exp_flat();
    logic [LW-1:0] f;
    for (int i = 0; i < NCH; i++) f[i*8 +: 8] = exp_lvl[i];
    return f;
  endfunction

  initial begin
    for (int i = 0; i < NCH; i++) exp_lvl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 levels after reset", level, '0);
    chk("R1 cascade after reset", LW'(sel_next), '0);

    set_sel(1'b1);
    // first byte: latency R9, MSB position R4
    @(negedge clk);
    din = 8'h80; shclk = ~shclk;
    @(negedge clk); @(negedge clk);
    chk("R9 not yet after two edges", LW'(level[7:0]), LW'(8'h00));
    @(negedge clk);
    chk("R9 visible after third edge", LW'(level[7:0]), LW'(8'h80));
    chk("R4 msb bit", LW'(level[7]), LW'(1'b1));
    exp_lvl[0] = 8'h80;
    @(negedge clk);
    for (int c = 1; c < NCH; c++) begin
      exp_lvl[c] = 8'(c * 37 + 5);
      edge_byte(exp_lvl[c]);
      if (c == NCH - 2) chk("R6 cascade low after 31", LW'(sel_next), '0);
    end
    chk("R6 cascade high after 32", LW'(sel_next), LW'(1'b1));
    chk("R2 both edges fill all channels", level, exp_flat());
    for (int c = 0; c < NCH; c++) chk("R3 channel order", LW'(level[c*8 +: 8]), LW'(exp_lvl[c]));

    for (int i = 0; i < 4; i++) edge_byte(8'hEE);
    chk("R7 extra edges ignored", level, exp_flat());
    chk("R7 cascade held", LW'(sel_next), LW'(1'b1));

    set_sel(1'b0);
    chk("R8 cascade cleared", LW'(sel_next), '0);
    chk("R8 levels kept", level, exp_flat());

    for (int i = 0; i < 6; i++) edge_byte(8'h11);
    chk("R5 deselected edges ignored", level, exp_flat());

    set_sel(1'b1);
    edge_byte(8'h5A);
    exp_lvl[0] = 8'h5A;
    chk("R8 pointer back at channel 1", level, exp_flat());

    set_sel(1'b0);
    set_sel(1'b1);
    for (int c = 0; c < NCH - 1; c++) begin
      exp_lvl[c] = 8'(c) ^ 8'hC3;
      edge_byte(exp_lvl[c]);
    end
    // coincident: shift change and deselect on the same edge
    @(negedge clk);
    din = 8'h77; shclk = ~shclk; sel = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 coincident deselect no write", level, exp_flat());
    chk("R6 coincident deselect no cascade", LW'(sel_next), '0);

    set_sel(1'b1);
    edge_byte(8'h3C);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    snap = level;
    chk("R1 mid-run reset clears", snap, '0);
    chk("R1 mid-run reset cascade", LW'(sel_next), '0);
    edge_byte(8'hA5);
    for (int i = 0; i < NCH; i++) exp_lvl[i] = 8'h00;
    exp_lvl[0] = 8'hA5;
    chk("R1 reset homes pointer", level, exp_flat());

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule